// File: doc/BRIEF.md
# Soft-Start and Overcurrent Retry Sequencer

This block is the digital controller that brings a synchronous buck regulator up and recovers it from overcurrent faults. When the bias supply is good and the enable level is high, it waits a fixed bias-settle delay. It then asks the overcurrent sampler to capture its trip level, and after that it raises a 6-bit reference code from zero to full scale in 64 equal steps. While the reference ramps, the switch enables stay low until the ramp has crossed a pre-biased output. If the output is already above target, they stay low for the whole ramp.

An overcurrent trip while the switches may be on turns them off at once and starts a retry. The retry waits two dummy ramp periods with the output off and then makes one real ramp attempt, without a new overcurrent sample. This repeats for as long as the fault returns. Dropping enable, or losing the power-good flag, sends the block back to idle. Enabling again runs the whole start-up sequence, including a fresh sample. All timing comes from one step counter that is independent of the switching clock. Parameter `STEP_TICKS` sets one ramp step, nominally 1/64 of 6.8 ms, and can be made small for simulation.

Top module: `softstart_retry_seq`

## Requirements
- R1: While `porGood` is low, and from reset, every output is 0. A fall of `porGood` in any phase forces all outputs to 0 on the next clock.
- R2: When `porGood` and `enable` are both high in idle, the block waits exactly `BIAS_STEPS*STEP_TICKS` cycles. In the next cycle it drives `sampleStart` high for exactly one cycle.
- R3: When `sampleDone` is high in the sample phase, a ramp begins on the next cycle with `refCode` = 0. The code rises by 1 every `STEP_TICKS` cycles and reaches 63. The ramp lasts `64*STEP_TICKS` cycles.
- R4: During a ramp, `hiGateEn` and `loGateEn` are 0 until `rampAboveOut` is seen high. From the next cycle they stay 1 until the ramp ends (output pre-biased below target).
- R5: After a ramp, `running`, `rampDone`, `hiGateEn` and `loGateEn` are 1 and `refCode` is held at 63. If `rampAboveOut` never rose, the gates stay 0 until this point (output pre-biased above target).
- R6: If `ocTrip` is high during a ramp or in run, the next cycle shows both gates 0, `refCode` 0, `running` 0 and `fault` 1.
- R7: A fault phase lasts `2*64*STEP_TICKS` cycles with both gates 0. A new ramp then starts with no `sampleStart` pulse, and a trip during that ramp starts another fault phase.
- R8: `enable` low forces all outputs to 0 on the next clock. A later re-enable repeats the full delay and issues a new `sampleStart` pulse.
- R9: `ocTrip` has no effect in idle, in the bias delay or in the sample phase. No fault is raised and the sequence timing is unchanged.
- R10: If `sampleDone` is already high when the sample phase begins, the ramp starts on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer timebase clock |
| rstN | input | 1 | Asynchronous active-low reset |
| porGood | input | 1 | Bias supply above its power-on threshold |
| enable | input | 1 | High to allow start-up, low to shut down |
| ocTrip | input | 1 | Overcurrent comparator has tripped |
| rampAboveOut | input | 1 | Reference ramp is above the sensed output |
| sampleDone | input | 1 | Overcurrent sampler finished its capture |
| refCode | output | 6 | Soft-start reference code to the DAC |
| sampleStart | output | 1 | One-cycle request to start the overcurrent sample |
| hiGateEn | output | 1 | High-side switch enable |
| loGateEn | output | 1 | Low-side switch enable |
| running | output | 1 | Regulating after a completed ramp |
| fault | output | 1 | In an overcurrent retry wait |
| rampDone | output | 1 | Ramp reached full scale and is held there |

## Verification
The assertions take the inputs as synchronous to `clk`. They also assume that `ocTrip` and `rampAboveOut` carry meaning only in the ramp and run phases, and that `sampleDone` carries meaning only in the sample phase. The stimulus changes every input only on the falling edge. Trips arrive as short pulses, either at the phases where they must act or at the phases where they must be ignored. `rampAboveOut` is raised once per ramp, or held low for the above-target case. `sampleDone` is either pulsed after a delay or held high before the sample phase to exercise the zero-length case.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_BIAS   = 3'd1,
    ST_SAMPLE = 3'd2,
    ST_RAMP   = 3'd3,
    ST_RUN    = 3'd4,
    ST_HICCUP = 3'd5
  } seqState_e;

  // strobes from control to the timebase/code datapath
  typedef struct packed {
    logic clrTime;   // restart tick and step counters
    logic codeZero;  // force reference code to zero
    logic codeFull;  // force reference code to full scale
    logic codeStep;  // advance code at the end of a step
  } seqCtl_t;
endpackage

// File: rtl/seq_timebase_dp.sv
module seq_timebase_dp
  import seq_pkg::*;
#(
  parameter int STEP_TICKS = 13281,
  parameter int CODE_W     = 6,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  output logic              stepTick,
  output logic [CNT_W-1:0]  stepCnt,
  output logic [CODE_W-1:0] refCode
);
  localparam int TICK_W = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(STEP_TICKS - 1);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic [TICK_W-1:0] tickCnt;

  assign stepTick = (tickCnt == TICK_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      stepCnt <= '0;
    end else if (ctl.clrTime) begin
      tickCnt <= '0;
      stepCnt <= '0;
    end else if (stepTick) begin
      tickCnt <= '0;
      stepCnt <= stepCnt + 1'b1;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                              refCode <= '0;
    else if (ctl.codeFull)                                  refCode <= CODE_MAX;
    else if (ctl.codeZero)                                  refCode <= '0;
    else if (ctl.codeStep && stepTick && refCode != CODE_MAX) refCode <= refCode + 1'b1;
  end

  // code only ever moves up by one, drops to zero, or stays
  assert_code_single_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (refCode != $past(refCode) && refCode != '0) |-> (refCode == $past(refCode) + 1'b1));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int CODE_W      = 6,
  parameter int BIAS_STEPS  = 64,
  parameter int RAMP_STEPS  = 64,
  parameter int DUMMY_STEPS = 128,
  parameter int CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porGood,
  input  logic              enable,
  input  logic              ocTrip,
  input  logic              rampAboveOut,
  input  logic              sampleDone,
  input  logic              stepTick,
  input  logic [CNT_W-1:0]  stepCnt,
  input  logic [CODE_W-1:0] refCode,
  output seqCtl_t           ctl,
  output logic              sampleStart,
  output logic              gateOn,
  output logic              running,
  output logic              fault
);
  localparam logic [CNT_W-1:0] BIAS_LAST  = CNT_W'(BIAS_STEPS - 1);
  localparam logic [CNT_W-1:0] RAMP_LAST  = CNT_W'(RAMP_STEPS - 1);
  localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(DUMMY_STEPS - 1);

  seqState_e stateQ, stateNext;
  logic      gateNext;
  logic      tripLive;

  assign tripLive = ocTrip && (stateQ == ST_RAMP || stateQ == ST_RUN);

  always_comb begin
    stateNext = stateQ;
    if (!porGood || !enable) begin
      stateNext = ST_IDLE;
    end else if (tripLive) begin
      stateNext = ST_HICCUP;
    end else begin
      unique case (stateQ)
        ST_IDLE:   stateNext = ST_BIAS;
        ST_BIAS:   if (stepTick && stepCnt == BIAS_LAST)  stateNext = ST_SAMPLE;
        ST_SAMPLE: if (sampleDone)                        stateNext = ST_RAMP;
        ST_RAMP:   if (stepTick && stepCnt == RAMP_LAST)  stateNext = ST_RUN;
        ST_HICCUP: if (stepTick && stepCnt == DUMMY_LAST) stateNext = ST_RAMP;
        ST_RUN:    stateNext = ST_RUN;
        default:   stateNext = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.clrTime  = (stateNext != stateQ);
    ctl.codeFull = (stateNext == ST_RUN);
    ctl.codeZero = (stateNext != ST_RUN) && !(stateNext == ST_RAMP && stateQ == ST_RAMP);
    ctl.codeStep = (stateNext == ST_RAMP) && (stateQ == ST_RAMP);
    gateNext     = (stateNext == ST_RUN) ||
                   (stateNext == ST_RAMP && stateQ == ST_RAMP && (gateOn || rampAboveOut));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ      <= ST_IDLE;
      gateOn      <= 1'b0;
      sampleStart <= 1'b0;
    end else begin
      stateQ      <= stateNext;
      gateOn      <= gateNext;
      sampleStart <= (stateNext == ST_SAMPLE) && (stateQ != ST_SAMPLE);
    end
  end

  assign running = (stateQ == ST_RUN);
  assign fault   = (stateQ == ST_HICCUP);

  assert_por_loss_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !porGood |=> (!gateOn && !running && !fault && refCode == '0));
  assert_sample_pulse_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    sampleStart |=> !sampleStart);
  assert_run_holds_full_R5: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (refCode == '1 && gateOn));
  assert_trip_cuts_gates_R6: assert property (@(posedge clk) disable iff (!rstN)
    (porGood && enable && ocTrip && (running || stateQ == ST_RAMP)) |=> (fault && !gateOn));
  assert_fault_gates_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (!gateOn && refCode == '0 && !sampleStart));
  assert_disable_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!running && !fault && !gateOn));
endmodule

// File: rtl/softstart_retry_seq.sv
module softstart_retry_seq
  import seq_pkg::*;
#(
  parameter int STEP_TICKS  = 13281,
  parameter int BIAS_STEPS  = 64,
  parameter int CODE_W      = 6,
  parameter int DUMMY_RAMPS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porGood,
  input  logic              enable,
  input  logic              ocTrip,
  input  logic              rampAboveOut,
  input  logic              sampleDone,
  output logic [CODE_W-1:0] refCode,
  output logic              sampleStart,
  output logic              hiGateEn,
  output logic              loGateEn,
  output logic              running,
  output logic              fault,
  output logic              rampDone
);
  localparam int RAMP_STEPS  = 2 ** CODE_W;
  localparam int DUMMY_STEPS = DUMMY_RAMPS * RAMP_STEPS;
  localparam int MAX_STEPS   = (BIAS_STEPS > DUMMY_STEPS) ? BIAS_STEPS : DUMMY_STEPS;
  localparam int CNT_W       = $clog2(MAX_STEPS + 1);

  seqCtl_t          ctl;
  logic             stepTick;
  logic [CNT_W-1:0] stepCnt;
  logic             gateOn;

  seq_timebase_dp #(
    .STEP_TICKS(STEP_TICKS), .CODE_W(CODE_W), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .stepTick(stepTick), .stepCnt(stepCnt), .refCode(refCode)
  );

  seq_ctrl #(
    .CODE_W(CODE_W), .BIAS_STEPS(BIAS_STEPS), .RAMP_STEPS(RAMP_STEPS),
    .DUMMY_STEPS(DUMMY_STEPS), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .porGood(porGood), .enable(enable),
    .ocTrip(ocTrip), .rampAboveOut(rampAboveOut), .sampleDone(sampleDone),
    .stepTick(stepTick), .stepCnt(stepCnt), .refCode(refCode),
    .ctl(ctl), .sampleStart(sampleStart), .gateOn(gateOn),
    .running(running), .fault(fault)
  );

  assign hiGateEn = gateOn;
  assign loGateEn = gateOn;
  assign rampDone = running;
endmodule

// File: tb/softstart_retry_seq_tb.sv
`timescale 1ns/1ps
module softstart_retry_seq_tb_top;
  localparam int STEP     = 3;
  localparam int BSTEPS   = 64;
  localparam int BIAS_CYC = BSTEPS * STEP;
  localparam int RAMP_CYC = 64 * STEP;
  localparam int HIC_CYC  = 2 * 64 * STEP;
  localparam int M_IDLE = 0, M_BIAS = 1, M_SAMP = 2, M_RAMP = 3, M_RUN = 4, M_HIC = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0, porGood = 1'b0, enable = 1'b0, ocTrip = 1'b0;
  logic rampAboveOut = 1'b0, sampleDone = 1'b0;
  logic [5:0] refCode;
  logic sampleStart, hiGateEn, loGateEn, running, fault, rampDone;

  always #4 clk = ~clk;

  softstart_retry_seq #(.STEP_TICKS(STEP), .BIAS_STEPS(BSTEPS), .CODE_W(6), .DUMMY_RAMPS(2)) dut_i (
    .clk(clk), .rstN(rstN), .porGood(porGood), .enable(enable), .ocTrip(ocTrip),
    .rampAboveOut(rampAboveOut), .sampleDone(sampleDone), .refCode(refCode),
    .sampleStart(sampleStart), .hiGateEn(hiGateEn), .loGateEn(loGateEn),
    .running(running), .fault(fault), .rampDone(rampDone)
  );

  int checks = 0, errors = 0, cyc = 0, pulses = 0;
  int mSt = M_IDLE, mT = 0;
  bit mGate = 0, mPulse = 0;

  // behavioural reference: phase and time spent in it
  always @(posedge clk) begin
    int nxt;
    bit g;
    if (!rstN) begin
      mSt = M_IDLE; mT = 0; mGate = 0; mPulse = 0;
    end else begin
      nxt = mSt;
      mPulse = 0;
      if (!porGood || !enable) nxt = M_IDLE;
      else if (ocTrip && (mSt == M_RAMP || mSt == M_RUN)) nxt = M_HIC;
      else if (mSt == M_IDLE) nxt = M_BIAS;
      else if (mSt == M_BIAS && mT + 1 == BIAS_CYC) nxt = M_SAMP;
      else if (mSt == M_SAMP && sampleDone) nxt = M_RAMP;
      else if (mSt == M_RAMP && mT + 1 == RAMP_CYC) nxt = M_RUN;
      else if (mSt == M_HIC && mT + 1 == HIC_CYC) nxt = M_RAMP;
      g = (nxt == M_RUN) || (nxt == M_RAMP && mSt == M_RAMP && (mGate || rampAboveOut));
      if (nxt != mSt) begin
        mT = 0;
        if (nxt == M_SAMP) mPulse = 1;
      end else mT = mT + 1;
      mSt = nxt;
      mGate = g;
    end
  end

  function automatic int mCode();
    if (mSt == M_RUN) return 63;
    if (mSt == M_RAMP) return (mT / STEP > 63) ? 63 : mT / STEP;
    return 0;
  endfunction

  task automatic fld(input string tag, input string nm, input int act, input int exp);
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, nm, act, exp, cyc);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      fld("R3", "refCode", int'(refCode), mCode());
      fld("R2", "sampleStart", int'(sampleStart), int'(mPulse));
      fld("R4", "hiGateEn", int'(hiGateEn), int'(mGate));
      fld("R4", "loGateEn", int'(loGateEn), int'(mGate));
      fld("R5", "running", int'(running), int'(mSt == M_RUN));
      fld("R5", "rampDone", int'(rampDone), int'(mSt == M_RUN));
      fld("R6", "fault", int'(fault), int'(mSt == M_HIC));
      if (sampleStart) pulses++;
    end
  end

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    checks++;
    fld(tag, nm, act, exp);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitPhase(input int s);
    for (int i = 0; i < 2000 && mSt != s; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int p0, t0;
    cycles(3);
    chk("R1", "refCode in reset", int'(refCode), 0);
    chk("R1", "gates in reset", int'(hiGateEn | loGateEn | running | fault), 0);
    rstN = 1'b1;
    cycles(2);
    chk("R1", "idle without porGood", int'(running | fault | sampleStart), 0);

    // normal start, pre-bias below target, delayed sample
    porGood = 1'b1; enable = 1'b1;
    t0 = cyc;
    waitPhase(M_SAMP);
    chk("R2", "delay length", cyc - t0, BIAS_CYC + 1);
    chk("R2", "sample pulse", int'(sampleStart), 1);
    cycles(5);
    sampleDone = 1'b1; cycles(1); sampleDone = 1'b0;
    cycles(30);
    chk("R3", "code mid ramp", int'(refCode), mCode());
    rampAboveOut = 1'b1;
    cycles(2);
    chk("R4", "gates after crossing", int'(hiGateEn & loGateEn), 1);
    waitPhase(M_RUN);
    cycles(1);
    chk("R5", "run code", int'(refCode), 63);
    chk("R5", "run flags", int'(running & rampDone & hiGateEn), 1);

    // trip in run, hiccup, real ramp without new sample, trip again
    p0 = pulses;
    ocTrip = 1'b1; cycles(1); ocTrip = 1'b0;
    chk("R6", "fault after trip", int'(fault), 1);
    chk("R6", "gates after trip", int'(hiGateEn | loGateEn | running), 0);
    waitPhase(M_RAMP);
    cycles(40);
    chk("R7", "no resample", pulses - p0, 0);
    ocTrip = 1'b1; cycles(1); ocTrip = 1'b0;
    chk("R7", "second fault", int'(fault), 1);
    waitPhase(M_RUN);
    cycles(1);
    chk("R7", "recovered run", int'(running), 1);
    chk("R7", "still no resample", pulses - p0, 0);

    // disable, trips ignored while idle/delay/sample, pre-bias above target
    enable = 1'b0; rampAboveOut = 1'b0;
    cycles(1);
    chk("R8", "disabled", int'(running | hiGateEn), 0);
    ocTrip = 1'b1; cycles(1); ocTrip = 1'b0;
    chk("R9", "trip in idle", int'(fault), 0);
    enable = 1'b1;
    cycles(50);
    ocTrip = 1'b1; cycles(1); ocTrip = 1'b0;
    chk("R9", "trip in delay", int'(fault), 0);
    waitPhase(M_SAMP);
    chk("R8", "new sample pulse", int'(sampleStart), 1);
    ocTrip = 1'b1; cycles(1); ocTrip = 1'b0;
    chk("R9", "trip in sample", int'(fault), 0);
    sampleDone = 1'b1; cycles(1); sampleDone = 1'b0;
    cycles(RAMP_CYC - 2);
    chk("R5", "gates held off above target", int'(hiGateEn | loGateEn), 0);
    waitPhase(M_RUN);
    cycles(1);
    chk("R5", "gates on at run", int'(hiGateEn & loGateEn), 1);

    // zero-length sample, then porGood loss mid ramp
    enable = 1'b0; cycles(2);
    sampleDone = 1'b1; enable = 1'b1;
    waitPhase(M_SAMP);
    cycles(1);
    chk("R10", "ramp right after sample", int'(mSt == M_RAMP && refCode == 0), 1);
    sampleDone = 1'b0;
    rampAboveOut = 1'b1;
    cycles(20);
    porGood = 1'b0;
    cycles(1);
    chk("R1", "por loss", int'(hiGateEn | running | fault | sampleStart), 0);
    chk("R1", "por loss code", int'(refCode), 0);
    cycles(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule